// File: doc/BRIEF.md
# DRAM Parallel Test-Mode Command Decoder

This block sits on the device side of an asynchronous DRAM pin interface. It samples the active-low row strobe, column strobe and write enable on a fast internal clock and sorts every strobe sequence into one of several kinds:
- an ordinary row/column access,
- a row-strobe-only refresh,
- a column-first refresh,
- a column-first refresh with write enable held low, which turns on a compressed test mode.

Once on, the test mode is held until a later refresh of either plain kind turns it off.

While test mode is on, one access covers eight storage bits at once. A write copies the single data bit into all eight. A read folds the eight bits into one pass/fail bit, which is high when they all agree. The folded result appears one clock later than a normal read result. A small cell array inside the block stores the bits, so the block can be checked on its own. The current mode and a code for the most recent cycle kind are visible as outputs.

Top module: `dram_test_mode`

## Requirements
- R1: After reset, test_mode is 0, cyc_type is 0 (idle) and dout_oe is 0.
- R2: A row-strobe fall seen while the column strobe is high gives cyc_type 1 (row open), and the address is taken as the row. The column strobe must also have been low in the sample before the row-strobe fall for the cycle to count as a refresh.
- R3: Each column-strobe fall while a row is open gives cyc_type 2 (access) and takes the address as the column. With we_n low it writes din, otherwise it reads. Several column falls may follow one row fall.
- R4: A row-strobe rise after a row open with no column fall gives cyc_type 3 (row-only refresh).
- R5: A column-first refresh with we_n high gives cyc_type 4. The same refresh with we_n low gives cyc_type 5 and sets test_mode.
- R6: test_mode stays set across accesses and repeated entry cycles. It clears only on a cycle of type 3 or type 4.
- R7: A test-mode write stores din into the eight cells that share the row and column address apart from the row MSB, the column MSB and column bit 0.
- R8: A test-mode read returns 1 when those eight cells hold equal values and 0 when any of them differ.
- R9: A normal read presents the addressed cell on dout one clock after the sample that sees the column fall. A test-mode read presents its result one clock later than that.
- R10: dout_oe is 1 from the moment read data is presented until the sample that sees the column strobe rise, and 0 at all other times. Refresh cycles never raise it.
- R11: In normal mode every row and column address bit selects a separate cell, so cells that differ only in the test-ignored bits do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Multiplexed row/column address |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data or test pass/fail bit |
| dout_oe | output | 1 | Output drive enable |
| test_mode | output | 1 | Latched test-mode flag |
| cyc_type | output | 3 | Most recent cycle kind: 0 idle, 1 row open, 2 access, 3 row-only refresh, 4 column-first refresh, 5 test entry |

## Verification
The strobe orderings are tried one at a time: a row fall with the column strobe high, a column-first refresh with write enable high, the same refresh with write enable low, and a row open that closes with no column fall. Each ordering must produce its own cycle code and its own effect on the mode flag. Test-mode reads are tried on groups written all-ones, all-zeros, and with one cell changed in normal mode, which separates the real equality fold from a single-cell read. Pairs of cells that differ only in the ignored bits show that normal mode keeps them apart and that test writes reach all eight. Counting the cycles to the output-enable rise separates the normal read latency from the longer test-mode latency.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  // cycle classification codes
  typedef enum logic [2:0] {
    CY_IDLE    = 3'd0,
    CY_ROWOPEN = 3'd1,
    CY_ACCESS  = 3'd2,
    CY_ROR     = 3'd3,
    CY_CBR     = 3'd4,
    CY_TEST    = 3'd5
  } cyc_e;

  // three address bits are ignored in test mode -> groups of eight
  localparam int GRP_BITS = 3;
  localparam int GRP_N    = 1 << GRP_BITS;

  // pass when every bit of the group agrees
  function automatic logic grp_agree(input logic [GRP_N-1:0] b);
    return (&b) | ~(|b);
  endfunction
endpackage

// File: rtl/dtm_edge.sv
module dtm_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_n,
  output logic [N-1:0] prev_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_n <= '1;
    else        prev_n <= sig_n;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign fall[i] = prev_n[i] & ~sig_n[i];
    assign rise[i] = ~prev_n[i] & sig_n[i];
  end
endmodule

// File: rtl/dtm_cycle_ctl.sv
module dtm_cycle_ctl
  import dtm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cas_q,
  input  logic ras_fall,
  input  logic ras_rise,
  input  logic cas_fall,
  output logic row_start,
  output logic acc_evt,
  output logic ror_evt,
  output logic cbr_evt,
  output logic ent_evt,
  output logic test_mode,
  output cyc_e cyc_type
);
  logic row_open_q, col_seen_q, refresh_start;
  cyc_e cyc_d;

  // column strobe low now and in the previous sample: refresh-type
  assign refresh_start = ras_fall & ~cas_n & ~cas_q;
  assign row_start     = ras_fall & ~refresh_start;
  assign acc_evt       = cas_fall & (row_open_q | row_start);
  assign ror_evt       = ras_rise & row_open_q & ~col_seen_q;
  assign cbr_evt       = refresh_start & we_n;
  assign ent_evt       = refresh_start & ~we_n;

  always_comb begin
    cyc_d = cyc_type;
    if (ent_evt)        cyc_d = CY_TEST;
    else if (cbr_evt)   cyc_d = CY_CBR;
    else if (acc_evt)   cyc_d = CY_ACCESS;
    else if (row_start) cyc_d = CY_ROWOPEN;
    else if (ror_evt)   cyc_d = CY_ROR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_mode  <= 1'b0;
      cyc_type   <= CY_IDLE;
      row_open_q <= 1'b0;
      col_seen_q <= 1'b0;
    end else begin
      cyc_type <= cyc_d;
      if (ent_evt)                test_mode <= 1'b1;
      else if (ror_evt | cbr_evt) test_mode <= 1'b0;
      if (row_start) begin
        row_open_q <= 1'b1;
        col_seen_q <= acc_evt;
      end else begin
        if (acc_evt)  col_seen_q <= 1'b1;
        if (ras_rise) row_open_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dtm_cell_array.sv
module dtm_cell_array
  import dtm_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          row_start,
  input  logic          acc_evt,
  input  logic          cas_rise,
  input  logic          we_n,
  input  logic          din,
  input  logic          test_mode,
  output logic [GRP_N-1:0] grp_bits,
  output logic          dout,
  output logic          dout_oe
);
  localparam int IW    = 2 * AW;
  localparam int DEPTH = 1 << IW;

  logic [DEPTH-1:0] cells;
  logic [AW-1:0]    row_q, cur_row;
  logic             stage_q, pend_q;

  function automatic logic [IW-1:0] cell_idx(input logic [AW-1:0] r, input logic [AW-1:0] c);
    return {r, c};
  endfunction

  // member k of the group: row MSB = k[2], column MSB = k[1], column LSB = k[0]
  function automatic logic [IW-1:0] grp_idx(input logic [AW-1:0] r, input logic [AW-1:0] c,
                                           input logic [GRP_BITS-1:0] k);
    logic [AW-1:0] rr, cc;
    rr = r; cc = c;
    rr[AW-1] = k[2];
    cc[AW-1] = k[1];
    cc[0]    = k[0];
    return {rr, cc};
  endfunction

  assign cur_row = row_start ? addr : row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         row_q <= '0;
    else if (row_start) row_q <= addr;
  end

  always_comb begin
    for (int k = 0; k < GRP_N; k++)
      grp_bits[k] = cells[grp_idx(cur_row, addr, GRP_BITS'(k))];
  end

  // storage is not reset, like the cells it models
  always_ff @(posedge clk) begin
    if (acc_evt && !we_n) begin
      if (test_mode) begin
        for (int k = 0; k < GRP_N; k++)
          cells[grp_idx(cur_row, addr, GRP_BITS'(k))] <= din;
      end else begin
        cells[cell_idx(cur_row, addr)] <= din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= 1'b0;
      dout_oe <= 1'b0;
      stage_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (cas_rise) begin
      dout_oe <= 1'b0;
      pend_q  <= 1'b0;
    end else if (acc_evt && we_n) begin
      if (test_mode) begin
        stage_q <= grp_agree(grp_bits);
        pend_q  <= 1'b1;
      end else begin
        dout    <= cells[cell_idx(cur_row, addr)];
        dout_oe <= 1'b1;
      end
    end else if (pend_q) begin
      dout    <= stage_q;
      dout_oe <= 1'b1;
      pend_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_test_mode.sv
module dram_test_mode
  import dtm_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          din,
  output logic          dout,
  output logic          dout_oe,
  output logic          test_mode,
  output logic [2:0]    cyc_type
);
  logic [1:0] strb_prev, strb_fall, strb_rise;
  logic ras_fall, ras_rise, cas_fall, cas_rise, cas_q;
  logic row_start, acc_evt, ror_evt, cbr_evt, ent_evt;
  logic [GRP_N-1:0] grp_bits;
  cyc_e cyc_w;

  dtm_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig_n({cas_n, ras_n}),
    .prev_n(strb_prev), .fall(strb_fall), .rise(strb_rise)
  );

  assign ras_fall = strb_fall[0];
  assign ras_rise = strb_rise[0];
  assign cas_fall = strb_fall[1];
  assign cas_rise = strb_rise[1];
  assign cas_q    = strb_prev[1];

  dtm_cycle_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cas_n(cas_n), .we_n(we_n), .cas_q(cas_q),
    .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall),
    .row_start(row_start), .acc_evt(acc_evt), .ror_evt(ror_evt),
    .cbr_evt(cbr_evt), .ent_evt(ent_evt), .test_mode(test_mode), .cyc_type(cyc_w)
  );

  assign cyc_type = cyc_w;

  dtm_cell_array #(.AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .addr(addr), .row_start(row_start),
    .acc_evt(acc_evt), .cas_rise(cas_rise), .we_n(we_n), .din(din),
    .test_mode(test_mode), .grp_bits(grp_bits), .dout(dout), .dout_oe(dout_oe)
  );
endmodule

// File: rtl/dtm_chk.sv
module dtm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       cas_fall,
  input logic       dout_oe,
  input logic       test_mode,
  input logic [2:0] cyc_type
);
  // R5: the mode turns on only after a row fall with column strobe and write enable low
  a_r5_entry_cond: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode) |-> (!$past(ras_n) && !$past(cas_n) && !$past(we_n)));

  // R6: the mode turns off only on a plain refresh cycle
  a_r6_exit_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_mode) |-> (cyc_type == 3'd3 || cyc_type == 3'd4));

  // R10: output drive only while the column strobe was low
  a_r10_oe_cas_low: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> !$past(cas_n));

  // R9: normal read latency
  a_r9_norm_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dout_oe) && !test_mode) |-> $past(cas_fall));

  // R9: test read latency is one clock longer
  a_r9_test_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dout_oe) && test_mode) |-> ($past(cas_fall, 2) && !$past(cas_fall)));
endmodule

bind dram_test_mode dtm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .cas_fall(cas_fall), .dout_oe(dout_oe), .test_mode(test_mode), .cyc_type(cyc_type)
);

// File: tb/sim_dram_test_mode.sv
module sim_dram_test_mode;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int NCELL = 1 << (2 * AW);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [AW-1:0] addr = '0;
  logic dout, dout_oe, test_mode;
  logic [2:0] cyc_type;

  int checks = 0, errors = 0;
  logic ref_m [NCELL];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_test_mode #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .test_mode(test_mode), .cyc_type(cyc_type)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int cidx(input int r, input int c);
    return r * (1 << AW) + c;
  endfunction

  task automatic open_row(input int r);
    addr = AW'(r); ras_n = 1'b0; tick();
  endtask

  task automatic close_row();
    ras_n = 1'b1; tick();
  endtask

  task automatic col_write(input int r, input int c, input logic d, input logic tm);
    addr = AW'(c); we_n = 1'b0; din = d; cas_n = 1'b0; tick();
    chk("R3 access code", 8'(cyc_type), 8'd2);
    cas_n = 1'b1; we_n = 1'b1; tick();
    if (tm) begin
      for (int rh = 0; rh < 2; rh++)
        for (int ch = 0; ch < 2; ch++)
          for (int cl = 0; cl < 2; cl++) begin
            int rr = (r & ((1 << (AW-1)) - 1)) | (rh << (AW-1));
            int cc = (c & ((1 << (AW-1)) - 2)) | (ch << (AW-1)) | cl;
            ref_m[cidx(rr, cc)] = d;
          end
    end else begin
      ref_m[cidx(r, c)] = d;
    end
  endtask

  task automatic col_read(input int c, input logic exp, input logic tm, input string req);
    addr = AW'(c); we_n = 1'b1; cas_n = 1'b0; tick();
    if (tm) begin
      chk("R9 test read not yet driven", 8'(dout_oe), 8'd0);
      tick();
    end
    chk("R10 oe during read", 8'(dout_oe), 8'd1);
    chk(req, 8'(dout), 8'(exp));
    cas_n = 1'b1; tick();
    chk("R10 oe off after column rise", 8'(dout_oe), 8'd0);
  endtask

  task automatic cbr(input logic we, input logic [2:0] exp_code);
    cas_n = 1'b0; we_n = we; tick();
    ras_n = 1'b0; tick();
    chk(we ? "R5 refresh code" : "R5 entry code", 8'(cyc_type), 8'(exp_code));
    chk("R10 no drive on refresh", 8'(dout_oe), 8'd0);
    ras_n = 1'b1; tick();
    cas_n = 1'b1; we_n = 1'b1; tick();
  endtask

  task automatic t_reset();
    chk("R1 test_mode reset", 8'(test_mode), 8'd0);
    chk("R1 cyc_type reset", 8'(cyc_type), 8'd0);
    chk("R1 dout_oe reset", 8'(dout_oe), 8'd0);
  endtask

  task automatic t_normal();
    // row 5 / row 13 differ only in row MSB; cols 6,7,14 differ in ignored bits
    open_row(5);
    chk("R2 row open code", 8'(cyc_type), 8'd1);
    col_write(5, 6, 1'b1, 1'b0);
    col_write(5, 7, 1'b0, 1'b0);
    col_write(5, 14, 1'b0, 1'b0);
    close_row();
    open_row(13);
    col_write(13, 6, 1'b0, 1'b0);
    close_row();
    open_row(5);
    col_read(6, 1'b1, 1'b0, "R11 normal read no alias");
    col_read(7, 1'b0, 1'b0, "R11 normal read col lsb");
    col_read(14, 1'b0, 1'b0, "R3 page read col msb");
    close_row();
    open_row(13);
    col_read(6, 1'b0, 1'b0, "R11 normal read row msb");
    close_row();
    chk("R6 still normal", 8'(test_mode), 8'd0);
  endtask

  task automatic t_refresh();
    open_row(2);
    close_row();
    chk("R4 row-only refresh code", 8'(cyc_type), 8'd3);
    chk("R4 no mode change", 8'(test_mode), 8'd0);
    cbr(1'b1, 3'd4);
    chk("R5 refresh keeps normal", 8'(test_mode), 8'd0);
  endtask

  task automatic t_test_mode();
    cbr(1'b0, 3'd5);
    chk("R5 entry sets mode", 8'(test_mode), 8'd1);
    open_row(3);
    col_write(3, 2, 1'b1, 1'b1);
    col_read(2, 1'b1, 1'b1, "R8 all ones pass");
    close_row();
    chk("R6 mode held after access", 8'(test_mode), 8'd1);
    cbr(1'b0, 3'd5);
    chk("R6 mode held after re-entry", 8'(test_mode), 8'd1);
    open_row(1);
    col_write(1, 4, 1'b0, 1'b1);
    col_read(4, 1'b1, 1'b1, "R8 all zeros pass");
    close_row();
    // exit through row-only refresh, then read every group member
    open_row(0);
    close_row();
    chk("R6 row-only refresh clears mode", 8'(test_mode), 8'd0);
    open_row(3);
    col_read(2, ref_m[cidx(3, 2)], 1'b0, "R7 group member r3c2");
    col_read(3, ref_m[cidx(3, 3)], 1'b0, "R7 group member r3c3");
    col_read(10, ref_m[cidx(3, 10)], 1'b0, "R7 group member r3c10");
    col_read(11, ref_m[cidx(3, 11)], 1'b0, "R7 group member r3c11");
    close_row();
    open_row(11);
    col_read(2, ref_m[cidx(11, 2)], 1'b0, "R7 group member r11c2");
    col_read(11, ref_m[cidx(11, 11)], 1'b0, "R7 group member r11c11");
    col_write(11, 10, 1'b0, 1'b0);
    close_row();
    cbr(1'b0, 3'd5);
    open_row(3);
    col_read(2, 1'b0, 1'b1, "R8 one differing cell fails");
    close_row();
    open_row(1);
    col_read(5, 1'b1, 1'b1, "R8 other group still passes");
    close_row();
    cbr(1'b1, 3'd4);
    chk("R6 column-first refresh clears mode", 8'(test_mode), 8'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_normal();
    t_refresh();
    t_test_mode();
    tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule